// File: doc/BRIEF.md
# Dual-Mode 16-Bit Counter/Timer

This block is a 16-bit down-counter for a peripheral register bus. It runs either as an event counter or as a square-wave timer. A 3-bit mode field selects the operating mode and also picks one of four tick sources:

- an external input pin,
- a transmit 1x clock enable from channel 1 or from channel 2,
- a crystal clock enable.

The pin and the crystal sources can also be divided by 16. The divide-by-16 stages are internal clock enables, and every source is handled in the system clock domain.

Software writes a 16-bit preset as two bytes. Reading one reserved address starts the block and reading another stops it, so neither command needs write data. Reading the high byte of the running value captures the low byte at the same moment, which keeps a two-read access consistent. A ready flag appears in bit 3 of an interrupt status byte and drives the interrupt output through a mask register. In timer mode the block also drives a square-wave output.

Top module: `ctr_timer16`

## Requirements
- R1: After reset the count is 0x0000, the status byte reads 0x00, and both `irq` and `sqw_out` are low.
- R2: A read at address 0 returns count[15:8] and captures count[7:0] in the same cycle. A read at address 1 returns the captured byte, not the live low byte. Writes to addresses 0 and 1 set preset[15:8] and preset[7:0].
- R3: A read at address 4 loads the preset into the count, clears ready, sets `sqw_out` high and starts the block. The new count is visible one clock later.
- R4: A read at address 5 halts the block and clears ready. While halted, ticks from any source leave the count unchanged.
- R5: The mode field is written and read back at address 2, bits [2:0]. The codes are:
  - 0: counter on pin rising edges
  - 1: counter on channel-1 enable
  - 2: counter on channel-2 enable
  - 3: counter on crystal enable / 16
  - 4: timer on pin rising edges
  - 5: timer on pin / 16
  - 6: timer on crystal enable
  - 7: timer on crystal enable / 16

  Only the selected source advances the count.
- R6: In counter modes (bit 2 of the mode clear) each tick decrements the count. Ready is set on the tick that brings the count to 0x0000. The next tick wraps the count to 0xFFFF and counting continues, with ready held.
- R7: In timer modes (bit 2 of the mode set) with preset P, each half period lasts max(P,1) ticks. When the count is at or below 1, a tick reloads P and toggles `sqw_out`. Ready is set on each low-to-high toggle.
- R8: A divided source produces its first tick on the 16th enable or pin edge after a start, because a start clears the dividers.
- R9: The pin passes through a two-stage synchroniser and only rising transitions count. A pin that goes high just before a clock edge changes the count at the third edge. A pin held high gives one tick.
- R10: A read at address 3 returns the status, with ready in bit 3. A write to address 3 sets the mask. `irq` is high when ready and mask bit 3 are both set. The mask has no effect on the status byte.
- R11: Writing the preset while the block runs does not change the count until the next start or timer reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (drives start, stop and capture side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on `addr` |
| ext_in | input | 1 | Asynchronous external input pin |
| xtal_en | input | 1 | Crystal-derived clock enable |
| tx1_en | input | 1 | Channel-1 transmit 1x clock enable |
| tx2_en | input | 1 | Channel-2 transmit 1x clock enable |
| irq | output | 1 | Masked ready interrupt |
| sqw_out | output | 1 | Timer square-wave output |

## Verification
Results arrive with fixed latencies:
- A start or stop read, or a clock-enable tick, shows in the count one edge after the strobe.
- A pin tick shows at the third edge after the pin is first sampled high.
- `rdata`, `irq` and the status byte follow combinationally from registers.

The bench drives inputs on falling edges and samples one nanosecond later. Each source pulse is followed by enough idle cycles for the synchroniser to settle before the count is read back. The pin latency is measured to the exact edge by watching `irq` with a preset of 1. Every mode is swept over several tick counts, and the expected count, `sqw_out` and ready are computed arithmetically for each step.

// File: rtl/ctr_timer16.sv
module ctr_timer16 #(
  parameter int PRESCALE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_in,
  input  logic       xtal_en,
  input  logic       tx1_en,
  input  logic       tx2_en,
  output logic       irq,
  output logic       sqw_out
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] DIV_TOP = PW'(PRESCALE - 1);
  localparam logic [3:0] A_HI = 4'd0, A_LO = 4'd1, A_MODE = 4'd2, A_IRQ = 4'd3,
                         A_START = 4'd4, A_STOP = 4'd5;

  logic [15:0] preset, cnt;
  logic [7:0]  lo_hold, mode_reg, mask_reg, status;
  logic [2:0]  mode, ext_sync;
  logic [PW-1:0] xdiv, ediv;
  logic run, ready, sqw;
  logic ext_tick, x16_tick, e16_tick, tick, start_rd, stop_rd;

  assign mode     = mode_reg[2:0];
  assign start_rd = rd_en && addr == A_START;
  assign stop_rd  = rd_en && addr == A_STOP;
  assign ext_tick = ext_sync[1] & ~ext_sync[2];
  assign x16_tick = xtal_en && xdiv == DIV_TOP;
  assign e16_tick = ext_tick && ediv == DIV_TOP;
  assign status   = {4'b0, ready, 3'b0};
  assign irq      = |(status & mask_reg);
  assign sqw_out  = sqw;

  always_comb begin
    case (mode)
      3'd0, 3'd4: tick = ext_tick;
      3'd1:       tick = tx1_en;
      3'd2:       tick = tx2_en;
      3'd5:       tick = e16_tick;
      3'd6:       tick = xtal_en;
      default:    tick = x16_tick;
    endcase
  end

  always_comb begin
    case (addr)
      A_HI:    rdata = cnt[15:8];
      A_LO:    rdata = lo_hold;
      A_MODE:  rdata = mode_reg;
      A_IRQ:   rdata = status;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sync <= '0;
      xdiv     <= '0;
      ediv     <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_in};
      if (start_rd) begin
        xdiv <= '0;
        ediv <= '0;
      end else begin
        if (xtal_en)  xdiv <= (xdiv == DIV_TOP) ? '0 : xdiv + 1'b1;
        if (ext_tick) ediv <= (ediv == DIV_TOP) ? '0 : ediv + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset   <= '0;
      cnt      <= '0;
      lo_hold  <= '0;
      mode_reg <= '0;
      mask_reg <= '0;
      run      <= 1'b0;
      ready    <= 1'b0;
      sqw      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_HI:    preset[15:8] <= wdata;
          A_LO:    preset[7:0]  <= wdata;
          A_MODE:  mode_reg     <= wdata;
          A_IRQ:   mask_reg     <= wdata;
          default: ;
        endcase
      end
      if (rd_en && addr == A_HI) lo_hold <= cnt[7:0];
      if (start_rd) begin
        cnt   <= preset;
        run   <= 1'b1;
        ready <= 1'b0;
        sqw   <= 1'b1;
      end else if (stop_rd) begin
        run   <= 1'b0;
        ready <= 1'b0;
      end else if (run && tick) begin
        if (!mode[2]) begin
          cnt <= cnt - 16'd1;
          if (cnt == 16'd1) ready <= 1'b1;
        end else if (cnt <= 16'd1) begin
          cnt <= preset;
          sqw <= ~sqw;
          if (!sqw) ready <= 1'b1;
        end else begin
          cnt <= cnt - 16'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ctr_timer16_chk.sv
module ctr_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [15:0] cnt,
  input logic [15:0] preset,
  input logic [2:0]  mode,
  input logic        run,
  input logic        ready,
  input logic        sqw
);
  logic start_rd, stop_rd;
  assign start_rd = rd_en && addr == 4'd4;
  assign stop_rd  = rd_en && addr == 4'd5;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> (cnt == $past(preset) && run && !ready && sqw)); // R3
  AST_STOP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rd |=> (!run && !ready)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_rd) |=> $stable(cnt)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mode[2] && !start_rd) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 16'd1)); // R6
  AST_READY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && $past(mode[2])) |-> $rose(sqw)); // R7
endmodule

bind ctr_timer16 ctr_timer16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .cnt(cnt),
  .preset(preset), .mode(mode), .run(run), .ready(ready), .sqw(sqw)
);

// File: tb/sim_ctr_timer16.sv
`timescale 1ns/1ps
module sim_ctr_timer16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic ext_in = 1'b0, xtal_en = 1'b0, tx1_en = 1'b0, tx2_en = 1'b0;
  logic irq, sqw_out;
  int nchk = 0, nfail = 0;
  logic [7:0] b;
  logic [15:0] v;

  always #5 clk = ~clk;

  ctr_timer16 u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] d);
    logic [7:0] h, l;
    rd(4'd0, h); rd(4'd1, l);
    d = {h, l};
  endtask

  task automatic setup(input logic [2:0] m, input logic [15:0] p);
    wr(4'd2, {5'b0, m}); wr(4'd0, p[15:8]); wr(4'd1, p[7:0]); rd(4'd4, b);
  endtask

  task automatic en_pulse(input int which);
    @(negedge clk);
    tx1_en = (which == 1); tx2_en = (which == 2); xtal_en = (which == 3);
    @(negedge clk);
    tx1_en = 1'b0; tx2_en = 1'b0; xtal_en = 1'b0;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_in = 1'b1;
    repeat (2) @(negedge clk);
    ext_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic one_tick(input int m);
    case (m)
      0, 4: ext_pulse();
      1: en_pulse(1);
      2: en_pulse(2);
      6: en_pulse(3);
      5: repeat (16) ext_pulse();
      default: repeat (16) en_pulse(3);
    endcase
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd16(v);        chk("R1 count", v, 16'h0000);
    rd(4'd3, b);    chk("R1 status", {8'h0, b}, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    chk("R1 sqw", {15'b0, sqw_out}, 16'h0000);

    for (int m = 0; m < 8; m++) begin
      int p = (m < 4) ? 3 : 2;
      setup(3'(m), 16'(p));
      rd(4'd2, b);  chk("R5 mode readback", {8'h0, b}, 16'(m));
      rd16(v);      chk("R3 start load", v, 16'(p));
      chk("R3 sqw high", {15'b0, sqw_out}, 16'h0001);
      for (int k = 1; k <= 6; k++) begin
        int tg;
        one_tick(m);
        rd16(v); rd(4'd3, b);
        if (m < 4) begin
          chk("R6 count", v, 16'(p - k));
          chk("R6 ready", {8'h0, b}, (k >= p) ? 16'h0008 : 16'h0000);
        end else begin
          tg = k / p;
          chk("R7 count", v, 16'(p - (k % p)));
          chk("R7 sqw", {15'b0, sqw_out}, (tg % 2 == 0) ? 16'h0001 : 16'h0000);
          chk("R7 ready", {8'h0, b}, (tg >= 2) ? 16'h0008 : 16'h0000);
        end
      end
    end

    setup(3'd1, 16'd10);
    en_pulse(2); en_pulse(3); ext_pulse();
    rd16(v); chk("R5 unselected ignored", v, 16'd10);
    en_pulse(1);
    rd16(v); chk("R5 selected counts", v, 16'd9);
    wr(4'd0, 8'h00); wr(4'd1, 8'h40);
    rd16(v); chk("R11 preset write no effect", v, 16'd9);
    en_pulse(1);
    rd16(v); chk("R11 continues", v, 16'd8);
    rd(4'd4, b);
    rd16(v); chk("R11 new preset on start", v, 16'h0040);

    setup(3'd3, 16'd5);
    repeat (15) en_pulse(3);
    rd16(v); chk("R8 no tick before 16", v, 16'd5);
    en_pulse(3);
    rd16(v); chk("R8 tick on 16th", v, 16'd4);

    setup(3'd1, 16'd2);
    repeat (3) en_pulse(1);
    rd16(v); chk("R6 wrap", v, 16'hFFFF);
    rd(4'd3, b); chk("R6 ready held", {8'h0, b}, 16'h0008);
    chk("R10 masked irq low", {15'b0, irq}, 16'h0000);
    wr(4'd3, 8'h08);
    chk("R10 irq unmasked", {15'b0, irq}, 16'h0001);
    wr(4'd3, 8'h00);
    rd(4'd3, b); chk("R10 status unaffected by mask", {8'h0, b}, 16'h0008);
    wr(4'd3, 8'h08);
    rd(4'd5, b);
    chk("R4 stop clears irq", {15'b0, irq}, 16'h0000);
    rd(4'd3, b); chk("R4 stop clears ready", {8'h0, b}, 16'h0000);
    en_pulse(1); en_pulse(1);
    rd16(v); chk("R4 halted count", v, 16'hFFFF);

    setup(3'd1, 16'h0100);
    rd(4'd0, b); chk("R2 high byte", {8'h0, b}, 16'h0001);
    en_pulse(1);
    rd(4'd1, b); chk("R2 captured low", {8'h0, b}, 16'h0000);
    rd16(v); chk("R2 fresh pair", v, 16'h00FF);

    setup(3'd6, 16'd0);
    en_pulse(3); chk("R7 preset0 toggle", {15'b0, sqw_out}, 16'h0000);
    en_pulse(3); chk("R7 preset0 rise", {15'b0, sqw_out}, 16'h0001);
    chk("R7 preset0 ready irq", {15'b0, irq}, 16'h0001);

    setup(3'd0, 16'd1);
    @(negedge clk); ext_in = 1'b1;
    @(negedge clk); chk("R9 edge 1", {15'b0, irq}, 16'h0000);
    @(negedge clk); chk("R9 edge 2", {15'b0, irq}, 16'h0000);
    @(negedge clk); chk("R9 edge 3", {15'b0, irq}, 16'h0001);
    repeat (3) @(negedge clk);
    ext_in = 1'b0;
    repeat (4) @(negedge clk);
    setup(3'd0, 16'd5);
    @(negedge clk); ext_in = 1'b1;
    repeat (10) @(negedge clk);
    rd16(v); chk("R9 held high one tick", v, 16'd4);
    ext_in = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule